// File: doc/BRIEF.md
# Co-issue Utilization Statistics Unit

This block watches the issue stage of a partitioned SIMD scheduler and keeps running 64-bit totals that describe how well co-issue fills the datapath. A qualifying cycle is one in which the partitioning feature is on and a composite instruction leaves the scheduler. In each such cycle the unit counts the cycle. It also adds up the active lanes carried by every valid SIMD set, and it records in a histogram how many sets the composite occupied.

Beside the composite view, the co-issue logic sends event strobes to the block. These mark granted inter-warp and intra-warp co-issues and the three reasons a candidate can be turned away: functional-unit mismatch, scoreboard hazard and lack of free sets. Each kind of event arrives as a vector of strobes, one per candidate examined in the cycle.

Software reads every total through a combinational register read port. It computes the average lanes per composite cycle itself, from the lane total and the cycle total, and takes zero when the cycle total is zero. A clear input zeroes every total at once. A single core is modelled.

Top module: `cos_stats_unit`

## Requirements
- R1: After synchronous reset every readable total reads zero.
- R2: The composite-cycle total, the lane total and the histogram bins change only in cycles where `part_en` and `comp_valid` are both high.
- R3: Each qualifying cycle adds exactly one to the composite-cycle total (read address 0).
- R4: Each qualifying cycle adds to the lane total (read address 1) the sum of the popcounts of the lane masks of the valid sets. The mask of a set whose valid bit is low has no effect. The mask of set s occupies bits [s*LANES +: LANES] of `set_mask`.
- R5: The histogram has HIST_SETS+1 bins, read at addresses 7 up to 7+HIST_SETS. A qualifying cycle adds one to the bin whose index equals the number of valid sets, and adds nothing to the other bins.
- R6: A valid-set count of HIST_SETS+1 or more is counted in the last bin.
- R7: The event totals are inter-warp grants (address 2), intra-warp grants (address 3), functional-unit-mismatch denials (address 4), scoreboard denials (address 5) and no-free-set denials (address 6). Each adds the number of strobe bits set in its input vector in every cycle, so several strobes in one cycle are all counted.
- R8: While `clr` is high, every total becomes zero in the next cycle, even if increments arrive in the same cycle.
- R9: `rd_data` shows the total at `rd_addr` with no clock delay. Addresses beyond the last histogram bin read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Zero all totals |
| part_en | input | 1 | SIMD partitioning enabled |
| comp_valid | input | 1 | Composite instruction issued this cycle |
| set_valid | input | NUM_SETS | Valid bit for each SIMD set of the composite |
| set_mask | input | NUM_SETS*LANES | Active lane mask for each set |
| inter_stb | input | STROBES | Inter-warp co-issue grant strobes |
| intra_stb | input | STROBES | Intra-warp co-issue grant strobes |
| deny_fu_stb | input | STROBES | Denials for functional-unit mismatch |
| deny_sb_stb | input | STROBES | Denials for scoreboard hazard |
| deny_ns_stb | input | STROBES | Denials for lack of free sets |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 64 | Total at the read address |

## Verification
The bench builds the block with four sets of eight lanes, a histogram limited to two sets (three bins) and two strobes per event kind. With the narrowed histogram, composites of three and four valid sets exercise the clamp into the last bin. They also give a lane total that mixes valid and invalid sets. Two strobe bits per kind make it possible to check that several events in one cycle are each counted, and the 5-bit address reaches past the last bin to show that out-of-range reads return zero.

// File: rtl/cos_pkg.sv
package cos_pkg;

    localparam int CNT_W = 64;
    localparam int ADD_W = 16;

    // register read map
    localparam int REG_CYC   = 0;
    localparam int REG_LANES = 1;
    localparam int REG_INTER = 2;
    localparam int REG_INTRA = 3;
    localparam int REG_DFU   = 4;
    localparam int REG_DSB   = 5;
    localparam int REG_DNS   = 6;
    localparam int REG_HIST0 = 7;

    typedef enum logic [2:0] {
        EV_INTER = 3'd0,
        EV_INTRA = 3'd1,
        EV_DFU   = 3'd2,
        EV_DSB   = 3'd3,
        EV_DNS   = 3'd4
    } ev_kind_e;

    function automatic int unsigned ones(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) n += int'(v[i]);
        return n;
    endfunction

endpackage

// File: rtl/cos_lane_sum.sv
module cos_lane_sum #(
    parameter int NUM_SETS = 4,
    parameter int LANES    = 8,
    localparam int SUM_W   = $clog2(NUM_SETS*LANES+1),
    localparam int VC_W    = $clog2(NUM_SETS+1)
) (
    input  logic [NUM_SETS-1:0]       set_valid,
    input  logic [NUM_SETS*LANES-1:0] set_mask,
    output logic [SUM_W-1:0]          lane_total,
    output logic [VC_W-1:0]           valid_cnt
);
    logic [SUM_W-1:0] per_set [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        always_comb begin
            per_set[s] = '0;
            if (set_valid[s])
                per_set[s] = SUM_W'(cos_pkg::ones(64'(set_mask[s*LANES +: LANES])));
        end
    end

    always_comb begin
        lane_total = '0;
        valid_cnt  = '0;
        for (int s = 0; s < NUM_SETS; s++) begin
            lane_total = lane_total + per_set[s];
            valid_cnt  = valid_cnt + VC_W'(set_valid[s]);
        end
    end
endmodule

// File: rtl/cos_counter.sv
module cos_counter
    import cos_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [ADD_W-1:0] add,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= cnt + CNT_W'(add);
    end

    // R8: a clear beats any same-cycle increment
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);
endmodule

// File: rtl/cos_stats_unit.sv
module cos_stats_unit
    import cos_pkg::*;
#(
    parameter int NUM_SETS  = 4,
    parameter int HIST_SETS = NUM_SETS,
    parameter int LANES     = 8,
    parameter int STROBES   = 2,
    parameter int ADDR_W    = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      part_en,
    input  logic                      comp_valid,
    input  logic [NUM_SETS-1:0]       set_valid,
    input  logic [NUM_SETS*LANES-1:0] set_mask,
    input  logic [STROBES-1:0]        inter_stb,
    input  logic [STROBES-1:0]        intra_stb,
    input  logic [STROBES-1:0]        deny_fu_stb,
    input  logic [STROBES-1:0]        deny_sb_stb,
    input  logic [STROBES-1:0]        deny_ns_stb,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [63:0]               rd_data
);
    localparam int BINS     = HIST_SETS + 1;
    localparam int NUM_REGS = REG_HIST0 + BINS;
    localparam int SUM_W    = $clog2(NUM_SETS*LANES+1);
    localparam int VC_W     = $clog2(NUM_SETS+1);
    localparam int NUM_EV   = 5;

    logic                upd;
    logic [SUM_W-1:0]    lane_total;
    logic [VC_W-1:0]     valid_cnt;
    logic [BINS-1:0]     hist_inc;
    int                  bin_sel;
    logic [STROBES-1:0]  ev_stb [NUM_EV];
    logic [ADD_W-1:0]    add_vec [NUM_REGS];
    logic [CNT_W-1:0]    cnt_vec [NUM_REGS];

    assign upd = part_en & comp_valid;

    assign ev_stb[EV_INTER] = inter_stb;
    assign ev_stb[EV_INTRA] = intra_stb;
    assign ev_stb[EV_DFU]   = deny_fu_stb;
    assign ev_stb[EV_DSB]   = deny_sb_stb;
    assign ev_stb[EV_DNS]   = deny_ns_stb;

    cos_lane_sum #(.NUM_SETS(NUM_SETS), .LANES(LANES)) u_lanes (
        .set_valid (set_valid),
        .set_mask  (set_mask),
        .lane_total(lane_total),
        .valid_cnt (valid_cnt)
    );

    // histogram bin pick with clamp into the last bin
    always_comb begin
        bin_sel = (int'(valid_cnt) >= BINS) ? BINS - 1 : int'(valid_cnt);
        for (int b = 0; b < BINS; b++) hist_inc[b] = upd && (bin_sel == b);
    end

    always_comb begin
        add_vec[REG_CYC]   = ADD_W'(upd);
        add_vec[REG_LANES] = upd ? ADD_W'(lane_total) : '0;
        for (int e = 0; e < NUM_EV; e++)
            add_vec[REG_INTER + e] = ADD_W'(ones(64'(ev_stb[e])));
        for (int b = 0; b < BINS; b++)
            add_vec[REG_HIST0 + b] = ADD_W'(hist_inc[b]);
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_cnt
        cos_counter u_cnt (
            .clk(clk),
            .rst(rst),
            .clr(clr),
            .add(add_vec[r]),
            .cnt(cnt_vec[r])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NUM_REGS; r++)
            if (rd_addr == ADDR_W'(r)) rd_data = cnt_vec[r];
    end

    // R2: without a qualifying cycle the composite totals hold
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(part_en && comp_valid)) |=>
            ($stable(cnt_vec[REG_CYC]) && $stable(cnt_vec[REG_LANES])));

    // R3: a qualifying cycle steps the composite-cycle total by one
    assert_cyc_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr && part_en && comp_valid) |=>
            cnt_vec[REG_CYC] == $past(cnt_vec[REG_CYC]) + 64'd1);

    // R5: at most one histogram bin advances per cycle
    assert_one_bin_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hist_inc));

    // R9: out-of-range reads return zero
    assert_oob_read_R9: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_addr) >= NUM_REGS) |-> rd_data == 64'd0);
endmodule

// File: tb/cos_stats_unit_tb.sv
module cos_stats_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS   = 4;
    localparam int HS   = 2;
    localparam int LN   = 8;
    localparam int ST   = 2;
    localparam int AW   = 5;
    localparam int NREG = 7 + HS + 1;

    logic clk = 0;
    logic rst = 1;
    logic clr = 0;
    logic part_en = 0;
    logic comp_valid = 0;
    logic [NS-1:0] set_valid = '0;
    logic [NS*LN-1:0] set_mask = '0;
    logic [ST-1:0] inter_stb = '0, intra_stb = '0;
    logic [ST-1:0] deny_fu_stb = '0, deny_sb_stb = '0, deny_ns_stb = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [63:0] rd_data;

    longint unsigned expv [NREG];
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cos_stats_unit #(.NUM_SETS(NS), .HIST_SETS(HS), .LANES(LN),
                     .STROBES(ST), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .clr(clr), .part_en(part_en),
        .comp_valid(comp_valid), .set_valid(set_valid), .set_mask(set_mask),
        .inter_stb(inter_stb), .intra_stb(intra_stb),
        .deny_fu_stb(deny_fu_stb), .deny_sb_stb(deny_sb_stb),
        .deny_ns_stb(deny_ns_stb), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int pc(input logic [31:0] v);
        int n = 0;
        for (int i = 0; i < 32; i++) if (v[i]) n++;
        return n;
    endfunction

    // one clock of stimulus, reference model updated after the edge
    task automatic step(input logic pe, input logic cv, input logic [NS-1:0] sv,
                        input logic [NS*LN-1:0] sm, input logic [ST-1:0] s_inter,
                        input logic [ST-1:0] s_intra, input logic [ST-1:0] s_fu,
                        input logic [ST-1:0] s_sb, input logic [ST-1:0] s_ns,
                        input logic cl);
        int lanes, nv, bin;
        @(negedge clk);
        part_en = pe; comp_valid = cv; set_valid = sv; set_mask = sm;
        inter_stb = s_inter; intra_stb = s_intra; deny_fu_stb = s_fu;
        deny_sb_stb = s_sb; deny_ns_stb = s_ns; clr = cl;
        @(posedge clk);
        #1;
        if (cl) begin
            for (int i = 0; i < NREG; i++) expv[i] = 0;
        end else begin
            if (pe && cv) begin
                lanes = 0; nv = 0;
                for (int s = 0; s < NS; s++)
                    if (sv[s]) begin
                        nv++;
                        lanes += pc(32'(sm[s*LN +: LN]));
                    end
                bin = (nv > HS) ? HS : nv;
                expv[0] += 1;
                expv[1] += longint'(lanes);
                expv[7 + bin] += 1;
            end
            expv[2] += longint'(pc(32'(s_inter)));
            expv[3] += longint'(pc(32'(s_intra)));
            expv[4] += longint'(pc(32'(s_fu)));
            expv[5] += longint'(pc(32'(s_sb)));
            expv[6] += longint'(pc(32'(s_ns)));
        end
        part_en = 0; comp_valid = 0; set_valid = '0; set_mask = '0;
        inter_stb = '0; intra_stb = '0; deny_fu_stb = '0;
        deny_sb_stb = '0; deny_ns_stb = '0; clr = 0;
    endtask

    task automatic chk(input string req, input int a);
        longint unsigned e;
        e = (a < NREG) ? expv[a] : 0;
        rd_addr = AW'(a);
        #1;
        n_chk++;
        if (rd_data !== e) begin
            n_bad++;
            $display("FAIL %s addr %0d: actual %0d expected %0d", req, a, rd_data, e);
        end
    endtask

    task automatic chk_all(input string req);
        for (int a = 0; a < NREG; a++) chk(req, a);
    endtask

    task automatic t_reset;
        for (int i = 0; i < NREG; i++) expv[i] = 0;
        chk_all("R1");
    endtask

    task automatic t_basic;
        // sets 0,1 valid (8 + 4 lanes); sets 2,3 invalid with nonzero masks
        step(1, 1, 4'b0011, 32'h01FF_0FFF, 0, 0, 0, 0, 0, 0);
        chk("R3", 0);
        chk("R4", 1);
        chk("R5", 9);
        step(1, 1, 4'b0101, 32'hFF03_FF01, 0, 0, 0, 0, 0, 0);
        chk("R3", 0);
        chk("R4", 1);
    endtask

    task automatic t_gate;
        step(0, 1, 4'b1111, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
        step(1, 0, 4'b1111, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
        chk_all("R2");
    endtask

    task automatic t_hist;
        step(1, 1, 4'b0000, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
        step(1, 1, 4'b1000, 32'h8000_0000, 0, 0, 0, 0, 0, 0);
        step(1, 1, 4'b1000, 32'h0300_0000, 0, 0, 0, 0, 0, 0);
        chk("R5", 7);
        chk("R5", 8);
        chk("R5", 9);
        chk("R4", 1);
    endtask

    task automatic t_clamp;
        step(1, 1, 4'b1111, 32'h0F0F_0F0F, 0, 0, 0, 0, 0, 0);
        step(1, 1, 4'b0111, 32'h00FF_FFFF, 0, 0, 0, 0, 0, 0);
        chk("R6", 9);
        chk("R6", 8);
        chk("R4", 1);
    endtask

    task automatic t_events;
        step(0, 0, '0, '0, 2'b11, 2'b00, 2'b01, 2'b11, 2'b10, 0);
        step(1, 1, 4'b0001, 32'h1, 2'b01, 2'b11, 2'b11, 2'b00, 2'b11, 0);
        for (int a = 2; a <= 6; a++) chk("R7", a);
    endtask

    task automatic t_clear;
        step(1, 1, 4'b1111, 32'hFFFF_FFFF, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 1);
        chk_all("R8");
        step(1, 1, 4'b0001, 32'h3, 0, 0, 0, 0, 0, 0);
        chk("R8", 0);
        chk("R8", 1);
    endtask

    task automatic t_read;
        chk("R9", NREG);
        chk("R9", 31);
        chk("R9", 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_basic();
        t_gate();
        t_hist();
        t_clamp();
        t_events();
        t_clear();
        t_read();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * CLK_PERIOD);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule